// File: doc/BRIEF.md
# GPIO Port Register Core

This block keeps the per-pin control state of a 24-pin general-purpose I/O expander, arranged as three 8-bit ports, and turns that state into pad controls. A byte-wide register interface (address, write data, write strobe, read strobe, read data) reaches one byte per port for each register kind. The serial bus front end that drives this interface lives outside the block.

For every pin the core combines direction, output value, polarity inversion and output type into an output enable and an output data bit. Pad levels come in through a two-flop synchronizer. They are read back through the same polarity inversion. The pull-resistor enable and pull direction bytes go straight out to the pad controls.

Top module: `gpio_port_core`

## Requirements
- R1: After rst_ni is asserted low, every pin is an input (direction bytes 0xFF), output bytes are 0xFF, and polarity, output type, pull enable and pull select bytes are 0x00. Every pad_oe_o and pull bit is 0.
- R2: The read/write register bytes sit at these addresses, port n at base+n (n = 0..2): output 0x04, polarity 0x08, direction 0x0C, pull enable 0x4C, pull select 0x50, output type 0x70. A write lands on the next clock edge, and a later read returns the byte that was written.
- R3: A read of 0x00+n returns the port-n pad levels, each bit XORed with its polarity bit. A pad change becomes readable two clock edges after it is sampled.
- R4: A direction bit of 1 makes the pin an input with pad_oe_o low. A bit of 0 makes it an output. Inputs and outputs may be mixed in any pattern within a port.
- R5: For a push-pull output (output type bit 0), pad_oe_o is 1 and pad_do_o equals the output bit XOR the polarity bit. In push-pull mode pad_do_o carries that value whatever the direction.
- R6: For an open-drain pin (output type bit 1), pad_do_o is 0. The driven value (output XOR polarity) of 0 sets pad_oe_o to 1, and a value of 1 releases the pad (pad_oe_o 0).
- R7: pull_en_o and pull_up_o show the pull enable and pull select bytes bit for bit, one edge after the write. A select bit of 1 means pull-up.
- R8: A read of any unmapped address returns 0x00. A write to an unmapped address, or to an input-port address, changes no state.
- R9: rdata_o is registered. It takes the addressed byte on the clock edge where rd_i is high and holds its value while rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pad_i | input | 24 | Pad input levels |
| pad_oe_o | output | 24 | Pad output enable per pin |
| pad_do_o | output | 24 | Pad output data per pin |
| pull_en_o | output | 24 | Pull resistor enable per pin |
| pull_up_o | output | 24 | Pull direction per pin, 1 = up |

## Verification
A corrupted register byte shows up on the pad outputs in the cycle after the write. It also shows up on rdata_o one edge after a read of that address. A wrong synchronizer depth or a missing inversion appears as a wrong input-port read value. The bench reads those values exactly two edges after a pad change. A stray write decode or a leak from an unmapped address shows up as a changed byte on the next readback or pad check, so every fault is visible within a few cycles.

// File: rtl/gpio_core_pkg.sv
package gpio_core_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DEF_PORT_W = 8;
  localparam int unsigned DEF_NUM_PORTS = 3;

  localparam logic [ADDR_W-1:0] A_IN    = 8'h00;
  localparam logic [ADDR_W-1:0] A_OUT   = 8'h04;
  localparam logic [ADDR_W-1:0] A_POL   = 8'h08;
  localparam logic [ADDR_W-1:0] A_DIR   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_PUEN  = 8'h4C;
  localparam logic [ADDR_W-1:0] A_PUSEL = 8'h50;
  localparam logic [ADDR_W-1:0] A_OTYPE = 8'h70;

  typedef enum logic {
    OT_PUSH_PULL  = 1'b0,
    OT_OPEN_DRAIN = 1'b1
  } otype_e;

  function automatic logic in_group(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base,
                                    input int unsigned n);
    return (a >= base) && (a < base + ADDR_W'(n));
  endfunction

  function automatic logic addr_mapped(input logic [ADDR_W-1:0] a,
                                       input int unsigned n);
    return in_group(a, A_IN, n)   || in_group(a, A_OUT, n)  ||
           in_group(a, A_POL, n)  || in_group(a, A_DIR, n)  ||
           in_group(a, A_PUEN, n) || in_group(a, A_PUSEL, n) ||
           in_group(a, A_OTYPE, n);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

  // warm-up counter so the latency check never looks before reset
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  p_sync_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_core_pkg::*;
#(
  parameter int unsigned      NUM_PORTS = DEF_NUM_PORTS,
  parameter int unsigned      PORT_W    = DEF_PORT_W,
  parameter logic [ADDR_W-1:0] BASE     = '0,
  parameter logic [PORT_W-1:0] RST_VAL  = '0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [PORT_W-1:0]           wdata_i,
  input  logic                        wr_i,
  output logic [NUM_PORTS*PORT_W-1:0] q_o,
  output logic [PORT_W-1:0]           rbyte_o
);
  logic [NUM_PORTS-1:0] sel;
  logic [PORT_W-1:0]    byte_q [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign sel[p] = (addr_i == BASE + ADDR_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              byte_q[p] <= RST_VAL;
      else if (wr_i && sel[p])  byte_q[p] <= wdata_i;
    end

    assign q_o[p*PORT_W +: PORT_W] = byte_q[p];

    p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && sel[p]) |=> (byte_q[p] == $past(wdata_i)));

    p_no_stray_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && sel[p]) |=> $stable(byte_q[p]));
  end

  always_comb begin
    rbyte_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel[p]) rbyte_o = rbyte_o | byte_q[p];
    end
  end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_core_pkg::*;
#(
  parameter int unsigned PIN_N = 24
) (
  input  logic [PIN_N-1:0] out_i,
  input  logic [PIN_N-1:0] pol_i,
  input  logic [PIN_N-1:0] dir_i,
  input  logic [PIN_N-1:0] otype_i,
  output logic [PIN_N-1:0] oe_o,
  output logic [PIN_N-1:0] do_o
);
  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    logic   drive;
    otype_e ot;
    assign drive = out_i[i] ^ pol_i[i];
    assign ot    = otype_e'(otype_i[i]);

    always_comb begin
      unique case (ot)
        OT_OPEN_DRAIN: begin
          oe_o[i] = ~dir_i[i] & ~drive;  // sink only, release for 1
          do_o[i] = 1'b0;
        end
        default: begin
          oe_o[i] = ~dir_i[i];
          do_o[i] = drive;
        end
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_core.sv
module gpio_port_core
  import gpio_core_pkg::*;
#(
  parameter int unsigned NUM_PORTS = DEF_NUM_PORTS,
  parameter int unsigned PORT_W    = DEF_PORT_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [PORT_W-1:0]           wdata_i,
  input  logic                        wr_i,
  input  logic                        rd_i,
  output logic [PORT_W-1:0]           rdata_o,
  input  logic [NUM_PORTS*PORT_W-1:0] pad_i,
  output logic [NUM_PORTS*PORT_W-1:0] pad_oe_o,
  output logic [NUM_PORTS*PORT_W-1:0] pad_do_o,
  output logic [NUM_PORTS*PORT_W-1:0] pull_en_o,
  output logic [NUM_PORTS*PORT_W-1:0] pull_up_o
);
  localparam int unsigned PIN_N = NUM_PORTS * PORT_W;
  localparam int unsigned NBANK = 6;

  logic [PIN_N-1:0]  out_v, pol_v, dir_v, otype_v, puen_v, pusel_v, pin_in;
  logic [PORT_W-1:0] bank_rd [NBANK];
  logic [PORT_W-1:0] in_rd, rd_next, rdata_q;

  gpio_sync #(.W(PIN_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_i), .q_o(pin_in)
  );

  gpio_reg_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .BASE(A_OUT),
                  .RST_VAL({PORT_W{1'b1}})) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .q_o(out_v), .rbyte_o(bank_rd[0])
  );

  gpio_reg_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .BASE(A_POL),
                  .RST_VAL('0)) u_pol (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .q_o(pol_v), .rbyte_o(bank_rd[1])
  );

  gpio_reg_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .BASE(A_DIR),
                  .RST_VAL({PORT_W{1'b1}})) u_dir (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .q_o(dir_v), .rbyte_o(bank_rd[2])
  );

  gpio_reg_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .BASE(A_PUEN),
                  .RST_VAL('0)) u_puen (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .q_o(puen_v), .rbyte_o(bank_rd[3])
  );

  gpio_reg_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .BASE(A_PUSEL),
                  .RST_VAL('0)) u_pusel (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .q_o(pusel_v), .rbyte_o(bank_rd[4])
  );

  gpio_reg_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .BASE(A_OTYPE),
                  .RST_VAL('0)) u_otype (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .q_o(otype_v), .rbyte_o(bank_rd[5])
  );

  gpio_pin_drive #(.PIN_N(PIN_N)) u_drive (
    .out_i(out_v), .pol_i(pol_v), .dir_i(dir_v), .otype_i(otype_v),
    .oe_o(pad_oe_o), .do_o(pad_do_o)
  );

  assign pull_en_o = puen_v;
  assign pull_up_o = pusel_v;

  // input port read: synchronized level through polarity
  always_comb begin
    in_rd = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr_i == A_IN + ADDR_W'(p))
        in_rd = pin_in[p*PORT_W +: PORT_W] ^ pol_v[p*PORT_W +: PORT_W];
    end
  end

  always_comb begin
    rd_next = in_rd;
    for (int b = 0; b < NBANK; b++) rd_next = rd_next | bank_rd[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_i)  rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !addr_mapped(addr_i, NUM_PORTS)) |=> (rdata_o == '0));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pull_chk
    p_pull_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == A_PUEN + ADDR_W'(p))
        |=> (pull_en_o[p*PORT_W +: PORT_W] == $past(wdata_i)));
  end
endmodule

// File: tb/tb_gpio_port_core.sv
`timescale 1ns/1ps
module tb_gpio_port_core;
  localparam int unsigned NP = 3;
  localparam int unsigned PW = 8;
  localparam int unsigned PN = NP * PW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    addr_i = '0;
  logic [PW-1:0] wdata_i = '0;
  logic          wr_i = 1'b0, rd_i = 1'b0;
  logic [PW-1:0] rdata_o;
  logic [PN-1:0] pad_i = '0;
  logic [PN-1:0] pad_oe_o, pad_do_o, pull_en_o, pull_up_o;

  always #2.5 clk_i = ~clk_i;

  gpio_port_core #(.NUM_PORTS(NP), .PORT_W(PW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .pad_i(pad_i),
    .pad_oe_o(pad_oe_o), .pad_do_o(pad_do_o),
    .pull_en_o(pull_en_o), .pull_up_o(pull_up_o)
  );

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [PW-1:0] exp;
    string         req;
  } sb_item_t;
  sb_item_t sb_q[$];

  // bench model of register state
  logic [PN-1:0] m_out = '1, m_pol = '0, m_dir = '1, m_ot = '0;

  task automatic check(input string req, input logic [PN-1:0] act,
                       input logic [PN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares read data one edge after each read strobe
  logic rd_d = 1'b0;
  always @(posedge clk_i) rd_d <= rd_i;
  always @(negedge clk_i) begin
    if (rd_d) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R9 actual=%h expected=<no item>", rdata_o);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (rdata_o !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.req, rdata_o, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [PW-1:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [PW-1:0] exp,
                    input string req);
    sb_item_t it;
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  function automatic void exp_pads(output logic [PN-1:0] oe,
                                   output logic [PN-1:0] dd);
    for (int i = 0; i < PN; i++) begin
      logic v;
      v = m_out[i] ^ m_pol[i];
      if (m_ot[i]) begin
        oe[i] = !m_dir[i] && !v;
        dd[i] = 1'b0;
      end else begin
        oe[i] = !m_dir[i];
        dd[i] = v;
      end
    end
  endfunction

  task automatic check_pads(input string req);
    logic [PN-1:0] eo, ed;
    exp_pads(eo, ed);
    check({req, " oe"}, pad_oe_o, eo);
    check({req, " do"}, pad_do_o, ed);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk_i);
    wait (sb_q.size() == 0);
    @(negedge clk_i);
  endtask

  task automatic run_tests();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check("R1 pad_oe", pad_oe_o, '0);
    check("R1 pull_en", pull_en_o, '0);
    check("R1 pull_up", pull_up_o, '0);
    check_pads("R1");
    for (int p = 0; p < NP; p++) begin
      rd(8'h04 + 8'(p), 8'hFF, "R1 out");
      rd(8'h0C + 8'(p), 8'hFF, "R1 dir");
      rd(8'h08 + 8'(p), 8'h00, "R1 pol");
      rd(8'h70 + 8'(p), 8'h00, "R1 otype");
      rd(8'h4C + 8'(p), 8'h00, "R1 puen");
      rd(8'h50 + 8'(p), 8'h00, "R1 pusel");
    end

    // R2 readback of each register kind
    wr(8'h05, 8'h3C); m_out[15:8] = 8'h3C;
    wr(8'h0A, 8'h81); m_pol[23:16] = 8'h81;
    wr(8'h0E, 8'h7E); m_dir[23:16] = 8'h7E;
    wr(8'h71, 8'h55); m_ot[15:8] = 8'h55;
    rd(8'h05, 8'h3C, "R2 out");
    rd(8'h0A, 8'h81, "R2 pol");
    rd(8'h0E, 8'h7E, "R2 dir");
    rd(8'h71, 8'h55, "R2 otype");
    settle();
    check_pads("R2");

    // R4 / R5: mixed direction, push-pull, then inversion
    wr(8'h04, 8'hA5); m_out[7:0] = 8'hA5;
    wr(8'h0C, 8'hF0); m_dir[7:0] = 8'hF0;
    check_pads("R4 mixed");
    check("R4 oe low nibble", {8'h0, pad_oe_o[7:0]}, {8'h0, 8'h0F});
    check("R5 push-pull do", {8'h0, pad_do_o[7:0]}, {8'h0, 8'hA5});
    wr(8'h08, 8'h03); m_pol[7:0] = 8'h03;
    check("R5 inverted do", {8'h0, pad_do_o[7:0]}, {8'h0, 8'hA6});
    check_pads("R5");

    // R6 open drain on pin 0 and 1
    wr(8'h70, 8'h03); m_ot[7:0] = 8'h03;
    // pin0 drive = 1^1 = 0 -> sink; pin1 drive = 0^1 = 1 -> release
    check("R6 od oe", {22'h0, pad_oe_o[1:0]}, {22'h0, 2'b01});
    check("R6 od do", {22'h0, pad_do_o[1:0]}, {22'h0, 2'b00});
    wr(8'h08, 8'h00); m_pol[7:0] = 8'h00;
    check("R6 od after pol", {22'h0, pad_oe_o[1:0]}, {22'h0, 2'b10});
    check_pads("R6");

    // R3 input read through sync and polarity
    @(negedge clk_i);
    pad_i = 24'h123456;
    repeat (2) @(negedge clk_i);
    rd(8'h00, 8'h56, "R3 port0");
    rd(8'h01, 8'h34, "R3 port1");
    rd(8'h02, 8'h12 ^ 8'h81, "R3 port2 inverted");
    // one edge after a change the old value must still be read
    @(negedge clk_i);
    pad_i = 24'h00FF00;
    addr_i = 8'h01; rd_i = 1'b1;
    begin sb_item_t it; it.exp = 8'h34; it.req = "R3 sync depth"; sb_q.push_back(it); end
    @(negedge clk_i);
    rd_i = 1'b0;
    rd(8'h01, 8'hFF, "R3 new value");

    // R7 pull outputs
    wr(8'h4D, 8'h3C);
    wr(8'h52, 8'hF0);
    check("R7 pull_en", pull_en_o, 24'h003C00);
    check("R7 pull_up", pull_up_o, 24'hF00000);
    rd(8'h4D, 8'h3C, "R7 puen read");

    // R8 unmapped and read-only addresses
    rd(8'h03, 8'h00, "R8 gap 0x03");
    rd(8'h7F, 8'h00, "R8 high addr");
    rd(8'h0F, 8'h00, "R8 after dir");
    wr(8'h03, 8'hAA);
    wr(8'h07, 8'hAA);
    wr(8'h01, 8'h00);
    rd(8'h03, 8'h00, "R8 gap write");
    rd(8'h01, 8'hFF, "R8 input write ignored");
    rd(8'h04, 8'hA5, "R8 out intact");
    settle();
    check_pads("R8");

    // R9 hold while rd_i is low
    pad_i = 24'h000000;
    repeat (4) @(negedge clk_i);
    check("R9 hold", {16'h0, rdata_o}, {16'h0, 8'hA5});
    settle();
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (200000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule